// File: doc/BRIEF.md
# I2C Target Receiver with Clock Stretch

This block is the receive half of an I2C target. It samples the open-drain SCL and SDA lines, finds start and stop conditions, and collects the first byte after a start as a 7-bit address plus a direction bit. If the address matches `own_addr_i` and the direction is write, the block pulls SDA low for the acknowledge clock. It does this on its own, with no host involvement. Every byte the controller writes after that is shifted in MSB first and placed in a one-entry receive buffer. The host reads the buffer through `rd_i`.

The first data byte goes into the empty buffer and is acknowledged straight away. A later byte can arrive while the host still has not read the previous one. In that case the block holds SCL low once the seventh bit of that byte has been clocked in. It keeps SCL low until the buffer is read, so no byte is overwritten. An address that does not match makes the block ignore the bus until the next start or stop. A stop returns the block to idle and produces a one-cycle flag.

Top module: `i2c_rx_target`

## Requirements
- R1: SCL and SDA pass through a two-flop synchroniser. A start (SDA falling while SCL is high) begins an address phase from any state. A stop (SDA rising while SCL is high) returns the block to idle.
- R2: When the 7 address bits (sent MSB first) equal `own_addr_i` and the eighth bit is 0 (write), the block drives SDA low through the whole ninth clock without any host action. It raises `sda_oe_o` only while SCL is low.
- R3: A non-matching address, or a matching address with the eighth bit set to 1 (read), gets no acknowledge. Data bytes that follow are neither acknowledged nor stored until the next start or stop.
- R4: Each data byte is received MSB first and appears on `rx_data_o` with `rx_full_o` set once the eighth bit has been sampled. It is acknowledged on the ninth clock. `rx_data_o` does not change while `rx_full_o` is high.
- R5: A one-cycle `rd_i` pulse while `rx_full_o` is high clears `rx_full_o` on the next clock. A pulse while the buffer is empty changes neither `rx_full_o` nor `rx_data_o`.
- R6: If the buffer is still full when SCL falls after the seventh bit of a data byte, `scl_oe_o` is raised and held until the buffer is read. It is released the cycle after `rx_full_o` clears, and the stalled byte is then received intact.
- R7: The block never drives SDA and SCL low together. The address acknowledge never stretches SCL.
- R8: A stop that ends an addressed transfer pulses `stop_o` for exactly one cycle. A stop after an ignored address produces no pulse.
- R9: A repeated start without a stop restarts the address phase. This includes the case where the bus was being ignored.
- R10: After reset no line is driven, `rx_full_o` and `stop_o` are 0, and `rx_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| own_addr_i | input | 7 | Address this target answers to |
| scl_i | input | 1 | SCL line as seen on the pad |
| sda_i | input | 1 | SDA line as seen on the pad |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| rx_data_o | output | 8 | Receive buffer contents |
| rx_full_o | output | 1 | Receive buffer holds an unread byte |
| rd_i | input | 1 | Host read strobe, one cycle |
| stop_o | output | 1 | One-cycle pulse on stop after an addressed transfer |

## Verification
The assertions rely on the controller following the protocol. SDA changes only while SCL is low, except when it forms a start or a stop. No start or stop is sent during the acknowledge clock, and the line levels stay steady for several system clocks so that the synchroniser sees each one. The host is assumed to strobe `rd_i` for one cycle at a time. The bench master keeps every quarter bit period at ten clocks. After releasing SCL it waits until the line is really high before it continues. The bench reader pulses `rd_i` only after it has seen `rx_full_o`, apart from one deliberate pulse on an empty buffer.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ACK,
    ST_DATA,
    ST_DATA_END,
    ST_IGNORE
  } rx_state_e;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;  // idle bus is high
      else         chain_q <= {chain_q[STAGES-2:0], in_i[g]};
    end
    assign out_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_rx_cond.sv
module i2c_rx_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_rx_buf.sv
module i2c_rx_buf #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic          full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (load_i) begin
      data_o <= data_i;
      full_o <= 1'b1;
    end else if (rd_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_rx_target.sv
module i2c_rx_target #(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] own_addr_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_full_o,
  input  logic          rd_i,
  output logic          stop_o
);
  import i2c_rx_pkg::*;

  localparam int SW       = (DW > AW + 1) ? DW : AW + 1;
  localparam int CW       = $clog2(SW + 1);
  localparam int STALL_AT = DW - 1;

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  rx_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] sh_q;
  logic sda_oe_q, stall_q, stop_q;
  logic load;
  logic [DW-1:0] load_data;
  logic addr_match, addressed;

  i2c_rx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   ({scl_i, sda_i}),
    .out_o  ({scl_s, sda_s})
  );

  i2c_rx_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  assign addr_match = (sh_q[AW:1] == own_addr_i) && !sh_q[0];
  assign addressed  = (state_q == ST_ACK) || (state_q == ST_DATA) ||
                      (state_q == ST_DATA_END);
  assign load       = !start_det && !stop_det && (state_q == ST_DATA) &&
                      scl_rise && (cnt_q == CW'(DW - 1));
  assign load_data  = {sh_q[DW-2:0], sda_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      sda_oe_q <= 1'b0;
      stall_q  <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      stop_q <= 1'b0;
      if (start_det) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
        stall_q  <= 1'b0;
      end else if (stop_det) begin
        stop_q   <= addressed;
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
        stall_q  <= 1'b0;
      end else begin
        if (stall_q && !rx_full_o) stall_q <= 1'b0;
        unique case (state_q)
          ST_ADDR: if (scl_rise) begin
            sh_q  <= {sh_q[SW-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(AW)) state_q <= ST_ADDR_END;
          end
          ST_ADDR_END: if (scl_fall) begin
            if (addr_match) begin
              sda_oe_q <= 1'b1;
              state_q  <= ST_ACK;
            end else begin
              state_q  <= ST_IGNORE;
            end
          end
          ST_ACK: if (scl_fall) begin
            sda_oe_q <= 1'b0;
            cnt_q    <= '0;
            state_q  <= ST_DATA;
          end
          ST_DATA: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[SW-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CW'(DW - 1)) state_q <= ST_DATA_END;
            end
            // buffer still occupied after bit 7: hold the clock low
            if (scl_fall && cnt_q == CW'(STALL_AT) && rx_full_o) stall_q <= 1'b1;
          end
          ST_DATA_END: if (scl_fall) begin
            sda_oe_q <= 1'b1;
            state_q  <= ST_ACK;
          end
          default: ;
        endcase
      end
    end
  end

  i2c_rx_buf #(.DW(DW)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (load_data),
    .rd_i   (rd_i),
    .data_o (rx_data_o),
    .full_o (rx_full_o)
  );

  assign scl_oe_o = stall_q;
  assign sda_oe_o = sda_oe_q;
  assign stop_o   = stop_q;
endmodule

// File: rtl/i2c_rx_target_chk.sv
module i2c_rx_target_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          scl_oe_o,
  input logic          sda_oe_o,
  input logic [DW-1:0] rx_data_o,
  input logic          rx_full_o,
  input logic          rd_i,
  input logic          stop_o
);
  AST_NO_DUAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sda_oe_o && scl_oe_o)); // R7
  AST_ACK_IN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s); // R2
  AST_STALL_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> rx_full_o); // R6
  AST_STALL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_oe_o && !rx_full_o) |=> !scl_oe_o); // R6
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && rd_i) |=> !rx_full_o); // R5
  AST_HOLD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o |=> $stable(rx_data_o)); // R4
  AST_STOP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o); // R8
endmodule

bind i2c_rx_target i2c_rx_target_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .scl_oe_o  (scl_oe_o),
  .sda_oe_o  (sda_oe_o),
  .rx_data_o (rx_data_o),
  .rx_full_o (rx_full_o),
  .rd_i      (rd_i),
  .stop_o    (stop_o)
);

// File: tb/i2c_rx_target_test.sv
module i2c_rx_target_test;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic rd = 1'b0;
  logic scl_oe, sda_oe, rx_full, stop_p;
  logic [7:0] rx_data;
  logic scl_bus, sda_bus;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  i2c_rx_target uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .own_addr_i (OWN),
    .scl_i      (scl_bus),
    .sda_i      (sda_bus),
    .scl_oe_o   (scl_oe),
    .sda_oe_o   (sda_oe),
    .rx_data_o  (rx_data),
    .rx_full_o  (rx_full),
    .rd_i       (rd),
    .stop_o     (stop_p)
  );

  int checks = 0, fails = 0;
  int stall_cnt = 0, stop_cnt = 0;
  int host_delay = 5;
  bit done = 0;
  logic [7:0] exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic m_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic m_bit(input logic b, output logic seen);
    m_sda = b; wq(); m_scl = 1'b1;
    while (!scl_bus) @(negedge clk);
    repeat (Q / 2) @(negedge clk);
    seen = sda_bus;
    repeat (Q - Q / 2) @(negedge clk);
    m_scl = 1'b0; wq();
  endtask

  task automatic m_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(b[i], s);
    m_bit(1'b1, s);
    ack = !s;
  endtask

  // monitor: stalls and stop pulses
  logic scl_oe_d = 1'b0;
  always @(negedge clk) begin
    if (scl_oe && !scl_oe_d) stall_cnt++;
    if (stop_p) stop_cnt++;
    scl_oe_d <= scl_oe;
  end

  // host reader / scoreboard consumer
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (rx_full) begin
        logic [7:0] e;
        repeat (host_delay) @(negedge clk);
        if (exp_q.size() == 0) begin
          check(0, "R4 unexpected byte", rx_data, 0);
        end else begin
          e = exp_q.pop_front();
          check(rx_data == e, "R4 data", rx_data, e);
        end
        rd = 1'b1; @(negedge clk); rd = 1'b0;
        @(negedge clk);
        check(!rx_full, "R5 read clears full", rx_full, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    int st0, sp0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    check(!rx_full && !stop_p, "R10 flags clear", {rx_full, stop_p}, 0);
    check(rx_data == 8'h00, "R10 data zero", rx_data, 0);

    // R5 read on empty buffer has no effect
    rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
    check(!rx_full && rx_data == 8'h00, "R5 empty read ignored", {rx_full, rx_data}, 0);

    // R1 R2 R4 R8: plain write, fast host
    st0 = stall_cnt; sp0 = stop_cnt;
    m_start();
    m_byte({OWN, 1'b0}, ack);
    check(ack, "R1 R2 address ack", ack, 1);
    exp_q.push_back(8'hA5); m_byte(8'hA5, ack);
    check(ack, "R4 data ack 1", ack, 1);
    exp_q.push_back(8'h3C); m_byte(8'h3C, ack);
    check(ack, "R4 data ack 2", ack, 1);
    m_stop();
    repeat (20) @(negedge clk);
    check(stop_cnt == sp0 + 1, "R8 stop pulse", stop_cnt - sp0, 1);
    check(stall_cnt == st0, "R7 no stretch when drained", stall_cnt - st0, 0);

    // R3 mismatched address: no ack, nothing stored, no stop pulse
    sp0 = stop_cnt;
    m_start();
    m_byte({7'h15, 1'b0}, ack);
    check(!ack, "R3 wrong address nack", ack, 0);
    m_byte(8'hFF, ack);
    check(!ack, "R3 ignored data nack", ack, 0);
    m_byte(8'h00, ack);
    m_stop();
    repeat (20) @(negedge clk);
    check(!rx_full, "R3 nothing stored", rx_full, 0);
    check(stop_cnt == sp0, "R8 no pulse when ignored", stop_cnt - sp0, 0);

    // R3 read direction not acknowledged
    m_start();
    m_byte({OWN, 1'b1}, ack);
    check(!ack, "R3 read bit nack", ack, 0);
    m_stop();
    repeat (20) @(negedge clk);

    // R6 slow host: stretch on later bytes, no loss
    host_delay = 1200;
    st0 = stall_cnt;
    m_start();
    m_byte({OWN, 1'b0}, ack);
    check(ack, "R7 address ack without stretch", ack, 1);
    check(stall_cnt == st0, "R7 address ack no stall", stall_cnt - st0, 0);
    exp_q.push_back(8'h81); m_byte(8'h81, ack);
    check(ack, "R6 byte 1 ack", ack, 1);
    exp_q.push_back(8'h7E); m_byte(8'h7E, ack);
    check(ack, "R6 byte 2 ack", ack, 1);
    exp_q.push_back(8'hC3); m_byte(8'hC3, ack);
    check(ack, "R6 byte 3 ack", ack, 1);
    m_stop();
    check(stall_cnt - st0 == 2, "R6 stretch count", stall_cnt - st0, 2);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    host_delay = 5;

    // R9 repeated start after ignored address
    m_start();
    m_byte({7'h55, 1'b0}, ack);
    m_byte(8'h99, ack);
    m_start();
    m_byte({OWN, 1'b0}, ack);
    check(ack, "R9 repeated start ack", ack, 1);
    exp_q.push_back(8'h5A); m_byte(8'h5A, ack);
    check(ack, "R9 data ack", ack, 1);
    m_stop();
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule